// File: doc/BRIEF.md
# Single-Line External Interrupt Controller

This block watches one asynchronous interrupt pin, such as a wake-up or non-maskable source, and turns it into a single interrupt request towards a parent controller. The pin first passes through a synchroniser. A two-bit trigger field then picks one of four conditions: two level conditions and two edge conditions. A matching condition latches a pending flag. When the line is enabled, that flag drives a registered interrupt output.

Software reaches three registers through a plain 32-bit register bus with an address, a write strobe, write data and read data that follows the address combinationally. The pending flag is cleared by writing a one to it. A build-time parameter picks where the three registers sit in the address space, so the same block fits three different register windows.

Top module: `extIrqTop`

## Requirements
- R1: The trigger field encodes 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge, and the pending flag follows the selected condition.
- R2: A write to the control register loads bits [1:0] of the write data into the trigger field. Bits above bit 1 of the control register always read as zero.
- R3: Pending status is bit 0 of the pending register. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R4: In an edge mode the flag sets on the selected transition of the synchronised input and holds until it is cleared.
- R5: In a level mode the flag is set again on every clock while the active level persists, so a clear does not stick. Once the level has gone away the flag stays set until it is cleared.
- R6: When a clear write and a new set condition fall in the same clock, the set wins and the flag stays 1.
- R7: Enable is bit 0 of the enable register and reads back. The interrupt output is the registered AND of the pending flag and the enable bit.
- R8: The input passes through two flops. After a pin change, the flag reads 1 after the third rising clock edge and the interrupt output rises after the fourth.
- R9: The parameter LAYOUT picks the register offsets (control, pending, enable): 0 gives 0x00, 0x04, 0x08; 1 gives 0x00, 0x08, 0x04; 2 gives 0x0C, 0x10, 0x40.
- R10: Reset clears every register to 0. Disabling the line and then clearing a stale flag raises no interrupt.
- R11: Reads from any address other than the three mapped ones return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinAsync | input | 1 | Asynchronous external interrupt pin |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for the addressed register |
| irqOut | output | 1 | Registered interrupt request to the parent controller |

## Verification
A software clear of the pending flag can land in the same clock in which the synchronised pin shows a fresh rising edge. The bench provokes this by releasing the pin two clocks ahead of the write, so the write commits on exactly the edge where the transition is detected. It then reads the pending flag on the next cycle and expects 1, because the new event must not be lost to the clear.

// File: rtl/extIrqPkg.sv
package extIrqPkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_LVL_HIGH = 2'd2,
    TRIG_RISE     = 2'd3
  } trigMode_e;

  // decoded bus action handed from control to datapath
  typedef struct packed {
    logic selCtrl;
    logic selPend;
    logic selEn;
    logic ctrlWr;
    logic enWr;
    logic pendClr;
  } regStrobe_t;

  function automatic int unsigned offCtrl(int unsigned layout);
    return (layout == 2) ? 32'h0C : 32'h00;
  endfunction

  function automatic int unsigned offPend(int unsigned layout);
    case (layout)
      1:       return 32'h08;
      2:       return 32'h10;
      default: return 32'h04;
    endcase
  endfunction

  function automatic int unsigned offEn(int unsigned layout);
    case (layout)
      1:       return 32'h04;
      2:       return 32'h40;
      default: return 32'h08;
    endcase
  endfunction

endpackage

// File: rtl/extIrqCtrl.sv
module extIrqCtrl
  import extIrqPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LAYOUT = 0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              wrBit0,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(offCtrl(LAYOUT));
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(offPend(LAYOUT));
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(offEn(LAYOUT));

  always_comb begin
    strobe.selCtrl = (busAddr == A_CTRL);
    strobe.selPend = (busAddr == A_PEND);
    strobe.selEn   = (busAddr == A_EN);
    strobe.ctrlWr  = busWrEn && strobe.selCtrl;
    strobe.enWr    = busWrEn && strobe.selEn;
    strobe.pendClr = busWrEn && strobe.selPend && wrBit0;
  end

endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinAsync,
  input  regStrobe_t        strobe,
  input  logic [1:0]        wrLow,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output trigMode_e         trig,
  output logic              pending,
  output logic              enable,
  output logic              syncd,
  output logic              prevS
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   setCond;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinAsync;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinAsync};
    end
  endgenerate

  assign syncd = syncQ[SYNC_STAGES-1];

  always_comb begin
    case (trig)
      TRIG_LVL_LOW:  setCond = !syncd;
      TRIG_FALL:     setCond = prevS && !syncd;
      TRIG_LVL_HIGH: setCond = syncd;
      default:       setCond = syncd && !prevS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevS   <= 1'b0;
      trig    <= TRIG_LVL_LOW;
      enable  <= 1'b0;
      pending <= 1'b0;
      irqOut  <= 1'b0;
    end else begin
      prevS <= syncd;
      if (strobe.ctrlWr) trig   <= trigMode_e'(wrLow);
      if (strobe.enWr)   enable <= wrLow[0];
      // a detected event outranks a simultaneous clear
      if (setCond)             pending <= 1'b1;
      else if (strobe.pendClr) pending <= 1'b0;
      irqOut <= pending && enable;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.selCtrl)      rdData[1:0] = trig;
    else if (strobe.selPend) rdData[0]   = pending;
    else if (strobe.selEn)   rdData[0]   = enable;
  end

endmodule

// File: rtl/extIrqTop.sv
module extIrqTop
  import extIrqPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinAsync,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  regStrobe_t strobe;
  trigMode_e  trig;
  logic       pending;
  logic       enable;
  logic       syncd;
  logic       prevS;
  logic       unusedWrBits;

  assign unusedWrBits = ^busWrData[DATA_W-1:2];

  extIrqCtrl #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .wrBit0  (busWrData[0]),
    .strobe  (strobe)
  );

  extIrqDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .pinAsync(pinAsync),
    .strobe  (strobe),
    .wrLow   (busWrData[1:0]),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .trig    (trig),
    .pending (pending),
    .enable  (enable),
    .syncd   (syncd),
    .prevS   (prevS)
  );

endmodule

// File: rtl/extIrqChk.sv
module extIrqChk
  import extIrqPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAYOUT = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              irqOut,
  input logic [1:0]        trig,
  input logic              pending,
  input logic              enable,
  input logic              syncd,
  input logic              prevS
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(offCtrl(LAYOUT));
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(offPend(LAYOUT));
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(offEn(LAYOUT));

  logic mapped, clrWr, ctrlWr, unusedChkBits;
  assign mapped = (busAddr == A_CTRL) || (busAddr == A_PEND) || (busAddr == A_EN);
  assign clrWr  = busWrEn && (busAddr == A_PEND) && busWrData[0];
  assign ctrlWr = busWrEn && (busAddr == A_CTRL);
  assign unusedChkBits = ^busWrData;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(pending && enable));

  // R3
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !clrWr) |=> pending);

  // R4
  rise_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pending) && $past(trig) == 2'd3) |-> ($past(syncd) && !$past(prevS)));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (trig == $past(busWrData[1:0])));

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (busRdData == '0));

  // R5
  level_reassert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trig == 2'd2 && syncd && !ctrlWr) |=> pending);

endmodule

bind extIrqTop extIrqChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .irqOut   (irqOut),
  .trig     (trig),
  .pending  (pending),
  .enable   (enable),
  .syncd    (syncd),
  .prevS    (prevS)
);

// File: tb/extIrqTop_tb.sv
module extIrqTop_tb_top;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_PEND = 8'h04;
  localparam logic [7:0] A_EN   = 8'h08;

  // {mode[1:0], pinStart, pinEnd, expectedPending}
  localparam logic [4:0] VEC [12] = '{
    {2'd0, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b1, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b1},
    {2'd3, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinAsync = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrEn = 1'b0, wrEnAlt = 1'b0, wrEnWide = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] rdMain, rdAlt, rdWide;
  logic irqMain, irqAlt, irqWide;
  int errors = 0;
  int checks = 0;
  logic irqSeen = 1'b0;

  always #4 clk = ~clk;

  extIrqTop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(0)) dut_i (
    .clk(clk), .rstN(rstN), .pinAsync(pinAsync), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(rdMain), .irqOut(irqMain));

  extIrqTop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(1)) dutAlt_i (
    .clk(clk), .rstN(rstN), .pinAsync(pinAsync), .busAddr(busAddr),
    .busWrEn(wrEnAlt), .busWrData(busWrData), .busRdData(rdAlt), .irqOut(irqAlt));

  extIrqTop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(2)) dutWide_i (
    .clk(clk), .rstN(rstN), .pinAsync(pinAsync), .busAddr(busAddr),
    .busWrEn(wrEnWide), .busWrData(busWrData), .busRdData(rdWide), .irqOut(irqWide));

  always @(posedge clk) if (irqMain) irqSeen <= 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // which: 0 main, 1 alternate layout, 2 wide layout
  task automatic wr(input int which, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d;
    busWrEn = (which == 0); wrEnAlt = (which == 1); wrEnWide = (which == 2);
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; wrEnAlt = 1'b0; wrEnWide = 1'b0;
  endtask

  task automatic rd(input int which, input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = (which == 0) ? rdMain : (which == 1) ? rdAlt : rdWide;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    // R10 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(0, A_CTRL, v); chk("R10 ctrl reset", v, 0);
    rd(0, A_PEND, v); chk("R10 pend reset", v, 0);
    rd(0, A_EN, v);   chk("R10 enable reset", v, 0);
    chk("R10 irq reset", {31'd0, irqMain}, 0);
    rstN = 1'b1;

    // R10 stale flag from synchroniser warm-up, then disable and clear
    waitCyc(4);
    wr(0, A_EN, 0);
    wr(0, A_PEND, 1);
    waitCyc(1);
    rd(0, A_PEND, v); chk("R10 stale cleared", v, 0);
    chk("R10 no spurious irq", {31'd0, irqSeen}, 0);

    // R2 only bits [1:0] kept
    wr(0, A_CTRL, 32'hFFFF_FFFE);
    rd(0, A_CTRL, v); chk("R2 ctrl upper bits", v, 2);

    // R1 R4 R5 R7 table walk with the line enabled
    wr(0, A_EN, 1);
    rd(0, A_EN, v); chk("R7 enable readback", v, 1);
    foreach (VEC[i]) begin
      wr(0, A_CTRL, {30'd0, VEC[i][4:3]});
      @(negedge clk); pinAsync = VEC[i][2];
      waitCyc(5);
      wr(0, A_PEND, 1);
      pinAsync = VEC[i][1];
      waitCyc(5);
      rd(0, A_PEND, v);
      chk($sformatf("R1 vec%0d pending", i), v, {31'd0, VEC[i][0]});
      chk($sformatf("R7 vec%0d irq", i), {31'd0, irqMain}, {31'd0, VEC[i][0]});
    end

    // R8 latency, rising mode
    wr(0, A_CTRL, 3);
    @(negedge clk); pinAsync = 1'b0;
    waitCyc(5);
    wr(0, A_PEND, 1);
    waitCyc(2);
    pinAsync = 1'b1;
    busAddr = A_PEND;
    waitCyc(2);
    rd(0, A_PEND, v); chk("R8 pending after two edges", v, 0);
    waitCyc(1);
    rd(0, A_PEND, v); chk("R8 pending after three edges", v, 1);
    chk("R8 irq after three edges", {31'd0, irqMain}, 0);
    waitCyc(1);
    chk("R8 irq after four edges", {31'd0, irqMain}, 1);

    // R3 write of 0 is ignored, write of 1 clears; R4 flag holds
    wr(0, A_PEND, 0);
    waitCyc(3);
    rd(0, A_PEND, v); chk("R3 write zero ignored", v, 1);
    wr(0, A_PEND, 1);
    rd(0, A_PEND, v); chk("R3 write one clears", v, 0);

    // R7 masking
    wr(0, A_CTRL, 1);
    @(negedge clk); pinAsync = 1'b0;
    waitCyc(5);
    wr(0, A_EN, 0);
    waitCyc(1);
    chk("R7 masked irq", {31'd0, irqMain}, 0);
    rd(0, A_PEND, v); chk("R7 pending while masked", v, 1);
    wr(0, A_EN, 1);
    waitCyc(1);
    chk("R7 unmasked irq", {31'd0, irqMain}, 1);

    // R6 clear coincides with a fresh rising edge
    wr(0, A_CTRL, 3);
    wr(0, A_PEND, 1);
    waitCyc(2);
    rd(0, A_PEND, v); chk("R6 precondition", v, 0);
    pinAsync = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(0, A_PEND, 1);
    waitCyc(1);
    rd(0, A_PEND, v); chk("R6 set beats clear", v, 1);

    // R11 unmapped offsets
    wr(0, 8'h0C, 32'hFFFF_FFFF);
    wr(0, 8'h40, 32'hFFFF_FFFF);
    rd(0, 8'h0C, v); chk("R11 unmapped read 0x0C", v, 0);
    rd(0, 8'h40, v); chk("R11 unmapped read 0x40", v, 0);
    rd(0, A_CTRL, v); chk("R11 ctrl untouched", v, 3);
    rd(0, A_EN, v);   chk("R11 enable untouched", v, 1);

    // R9 alternate and wide layouts
    wr(1, 8'h04, 1);
    rd(1, 8'h04, v); chk("R9 alt enable at 0x04", v, 1);
    wr(1, 8'h00, 2);
    rd(1, 8'h00, v); chk("R9 alt ctrl at 0x00", v, 2);
    wr(2, 8'h40, 1);
    rd(2, 8'h40, v); chk("R9 wide enable at 0x40", v, 1);
    wr(2, 8'h0C, 3);
    rd(2, 8'h0C, v); chk("R9 wide ctrl at 0x0C", v, 3);
    rd(2, 8'h00, v); chk("R9 wide 0x00 unmapped", v, 0);
    rd(2, 8'h04, v); chk("R9 wide 0x04 unmapped", v, 0);

    finishRun();
  end

endmodule